// File: doc/BRIEF.md
# Threshold-Gated Transmit Channel Buffer

This block is a single-channel transmit buffer between an application that produces 32-bit samples and a framing stage that consumes them. Writes arrive on a streaming interface with a ready latency of one cycle. The buffer raises its ready output while its fill level is no higher than a programmable threshold. The application may then present one valid word in each cycle that follows a cycle with ready high.

The read side is gated. No word leaves the buffer until the fill level has climbed to the threshold. From then on, the framing stage pops one word for each cycle in which it requests one, until the buffer runs dry. Because of this gating, the delay through the buffer depends on the threshold and on the fill level. The threshold is an input, so several channel instances can share one value while each instance reaches it on its own schedule.

A 3-bit status output reports three things: two sticky error flags (overflow and underflow) and whether the channel is currently draining.

Top module: `tx_thr_buffer`

## Requirements
- R1: The effective threshold E is the `thr_cfg` value limited to at most DEPTH-2 (14 with default parameters). `wr_ready` is high exactly when reset is low and the fill level is less than or equal to E.
- R2: Start from an empty buffer with no reads, and let an application assert `wr_valid` only in a cycle that follows a cycle with `wr_ready` high. Such an application gets exactly E+2 words accepted and never causes an overflow.
- R3: Words leave in the order they were written, with all 32 bits intact. Each popped word appears on `rd_data` with `rd_valid` high in the cycle after the popping request.
- R4: Draining starts only when the fill level is nonzero and at least E, so N = max(E,1) words must be present before any word is read. Status bit 2 (draining) rises in the cycle after the fill level reaches N.
- R5: While draining, each cycle with `rd_req` high and a nonempty buffer pops exactly one word. Draining ends, and status bit 2 falls, one cycle after the buffer is seen empty. After that the channel re-arms and again waits for the threshold.
- R6: A write presented while the buffer holds DEPTH words is dropped and sets sticky status bit 0 (overflow). The words already stored are unaffected.
- R7: `rd_req` while draining and empty sets sticky status bit 1 (underflow). `rd_req` while not draining has no effect: no word is output and no flag is set.
- R8: `clr_sticky` clears status bits 0 and 1 at the next clock edge. An error event in the same cycle wins over the clear.
- R9: Reset is synchronous and active high. It empties the buffer, ends draining, clears all status bits and holds `wr_ready` low. `wr_ready` is high in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_cfg | input | 5 | Ready/drain threshold, shared by channels |
| clr_sticky | input | 1 | Clears the sticky error status bits |
| wr_ready | output | 1 | Buffer can take a word in the next cycle |
| wr_valid | input | 1 | Application presents a word |
| wr_data | input | 32 | Application sample |
| rd_req | input | 1 | Framing side asks for a word |
| rd_valid | output | 1 | `rd_data` holds a popped word |
| rd_data | output | 32 | Popped sample |
| status | output | 3 | {draining, underflow, overflow} |

## Verification
The bench builds the block with its default values: DEPTH 16, a 5-bit threshold and 32-bit data. Because the threshold field is only 5 bits wide, every value 0 to 20 can be swept, which covers the clamp both below and above the DEPTH-2 limit. For each threshold, the bench computes the exact number of accepted words under the one-cycle-latency protocol, the size of the drain start point and the drain timing, and it checks ready against the fill level on every cycle. The same sweep fills the buffer completely, overflows it, underflows it, and resets it while it holds data.

// File: rtl/thrbuf_pkg.sv
package thrbuf_pkg;

    // Status word carried to the output port: {draining, underflow, overflow}
    typedef struct packed {
        logic drain;
        logic udf;
        logic ovf;
    } thrbuf_status_t;

    typedef enum logic {
        DS_FILL  = 1'b0,
        DS_DRAIN = 1'b1
    } drain_state_t;

    // Threshold limit keeps one word of headroom for the ready latency
    function automatic int unsigned clamp_thr(int unsigned thr, int unsigned limit);
        return (thr > limit) ? limit : thr;
    endfunction

endpackage

// File: rtl/thrbuf_store.sv
module thrbuf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    generate
        if (POW2) begin : g_wrap_nat
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= pop;
            if (push) begin
                wr_ptr <= wr_nxt;
            end
            if (pop) begin
                rd_ptr  <= rd_nxt;
                rd_data <= mem[rd_ptr];
            end
        end
    end
endmodule

// File: rtl/thrbuf_level.sv
module thrbuf_level #(
    parameter int DEPTH  = 16,
    parameter int THR_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [THR_W-1:0] thr_cfg,
    output logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] thr_eff,
    output logic             full,
    output logic             wr_ready
);
    localparam int unsigned THR_MAX = DEPTH - 2;

    logic [CNT_W-1:0] fill_q;

    assign thr_eff  = CNT_W'(thrbuf_pkg::clamp_thr(32'(thr_cfg), THR_MAX));
    assign full     = (fill_q == CNT_W'(DEPTH));
    assign wr_ready = !rst && (fill_q <= thr_eff);
    assign fill     = fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/thrbuf_drain.sv
module thrbuf_drain #(
    parameter int CNT_W = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr_sticky,
    input  logic                       rd_req,
    input  logic                       ovf_evt,
    input  logic [CNT_W-1:0]           fill,
    input  logic [CNT_W-1:0]           thr_eff,
    output logic                       pop,
    output thrbuf_pkg::thrbuf_status_t status
);
    import thrbuf_pkg::*;

    drain_state_t   state_q, state_d;
    thrbuf_status_t stat_q;
    logic           nonempty, udf_evt;

    assign nonempty = (fill != '0);
    assign pop      = (state_q == DS_DRAIN) && rd_req && nonempty;
    assign udf_evt  = (state_q == DS_DRAIN) && rd_req && !nonempty;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_FILL:  if (nonempty && (fill >= thr_eff)) state_d = DS_DRAIN;
            DS_DRAIN: if (!nonempty)                     state_d = DS_FILL;
            default:  state_d = DS_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_FILL;
            stat_q  <= '0;
        end else begin
            state_q     <= state_d;
            stat_q.drain <= (state_d == DS_DRAIN);
            stat_q.ovf  <= (stat_q.ovf & ~clr_sticky) | ovf_evt;
            stat_q.udf  <= (stat_q.udf & ~clr_sticky) | udf_evt;
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/tx_thr_buffer.sv
module tx_thr_buffer #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int THR_W  = 5,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [THR_W-1:0]  thr_cfg,
    input  logic              clr_sticky,
    output logic              wr_ready,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        status
);
    import thrbuf_pkg::*;

    logic           push, pop, full, ovf_evt;
    logic [CNT_W-1:0] fill, thr_eff;
    thrbuf_status_t stat;

    assign push    = wr_valid && !full;
    assign ovf_evt = wr_valid && full;

    thrbuf_level #(.DEPTH(DEPTH), .THR_W(THR_W)) u_level (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .thr_cfg  (thr_cfg),
        .fill     (fill),
        .thr_eff  (thr_eff),
        .full     (full),
        .wr_ready (wr_ready)
    );

    thrbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_data  (wr_data),
        .pop      (pop),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    thrbuf_drain #(.CNT_W(CNT_W)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .clr_sticky (clr_sticky),
        .rd_req     (rd_req),
        .ovf_evt    (ovf_evt),
        .fill       (fill),
        .thr_eff    (thr_eff),
        .pop        (pop),
        .status     (stat)
    );

    assign status = stat;
endmodule

// File: rtl/thrbuf_chk.sv
module thrbuf_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_sticky,
    input logic             wr_ready,
    input logic             rd_valid,
    input logic [2:0]       status,
    input logic [CNT_W-1:0] fill
);
    AST_READY_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> wr_ready);                                     // R1

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));                                         // R6

    AST_RD_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(status[2]) || status[2]);                    // R4

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (status[2] && fill > 1) |=> status[2]);                         // R5

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !clr_sticky) |=> status[0]);                      // R6

    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !clr_sticky) |=> status[1]);                      // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (status == 3'b000 && !rd_valid && fill == '0));         // R9
endmodule

bind tx_thr_buffer thrbuf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_sticky (clr_sticky),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .status     (status),
    .fill       (fill)
);

// File: tb/tx_thr_buffer_tb.sv
module tx_thr_buffer_tb;
    localparam int DEPTH = 16;
    localparam int EMAX  = DEPTH - 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  thr_cfg = '0;
    logic        clr_sticky = 1'b0;
    logic        wr_ready;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [2:0]  status;

    int checks = 0;
    int fails  = 0;
    int out_cnt = 0;
    logic [31:0] got [4096];
    bit done = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    tx_thr_buffer u_dut (
        .clk(clk), .rst(rst), .thr_cfg(thr_cfg), .clr_sticky(clr_sticky),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .status(status)
    );

    always @(negedge clk) begin
        if (rd_valid) begin
            got[out_cnt % 4096] = rd_data;
            out_cnt = out_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_valid = 1'b0; rd_req = 1'b0; clr_sticky = 1'b0;
        @(negedge clk);
        check("R9 ready low in reset", {31'd0, wr_ready}, 32'd0);
        rst = 1'b0;
        #0.1;
        check("R9 ready first cycle", {31'd0, wr_ready}, 32'd1);
        check("R9 status cleared", {29'd0, status}, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_seq(input string req, input int mark, input int n, input logic [31:0] base);
        check({req, " count"}, out_cnt - mark, n);
        for (int i = 0; i < n; i++)
            check({req, " data"}, got[(mark + i) % 4096], base + i);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t <= 20; t++) begin
            int e, n, mark, cnt;
            logic [31:0] base;
            bit prev_rdy;
            e = (t > EMAX) ? EMAX : t;
            n = (e > 1) ? e : 1;
            thr_cfg = 5'(t);

            // Phase A: drain gating, pop rate, underflow
            base = 32'hA500_0000 + (t << 8);
            do_reset();
            mark = out_cnt;
            rd_req = 1'b1;
            for (int i = 0; i < n - 1; i++) begin
                wr_valid = 1'b1; wr_data = base + i;
                @(negedge clk);
            end
            wr_valid = 1'b0;
            idle(3);
            check("R4 no output below threshold", out_cnt - mark, 0);
            check("R4 not draining below threshold", {31'd0, status[2]}, 32'd0);
            check("R7 request while filling ignored", {31'd0, status[1]}, 32'd0);
            wr_valid = 1'b1; wr_data = base + n - 1;
            @(negedge clk);
            wr_valid = 1'b0;
            check("R4 drain flag not yet", {31'd0, status[2]}, 32'd0);
            @(negedge clk);
            check("R4 drain flag rises", {31'd0, status[2]}, 32'd1);
            idle(n + 4);
            check_seq("R5 drained words", mark, n, base);
            check("R7 underflow sticky", {31'd0, status[1]}, 32'd1);
            check("R5 drain re-armed", {31'd0, status[2]}, 32'd0);
            rd_req = 1'b0;
            clr_sticky = 1'b1;
            @(negedge clk);
            clr_sticky = 1'b0;
            check("R8 sticky cleared", {29'd0, status}, 32'd0);

            // Phase B: ready-latency-1 streaming
            base = 32'h5A00_0000 + (t << 8);
            do_reset();
            mark = out_cnt;
            cnt = 0;
            prev_rdy = 1'b0;
            for (int c = 0; c < DEPTH + 4; c++) begin
                @(negedge clk);
                if (wr_valid) cnt++;
                check("R1 ready vs fill", {31'd0, wr_ready}, {31'd0, (cnt <= e)});
                wr_valid = prev_rdy;
                wr_data = base + cnt;
                prev_rdy = wr_ready;
            end
            @(negedge clk);
            if (wr_valid) cnt++;
            wr_valid = 1'b0;
            check("R2 accepted words", cnt, e + 2);
            check("R2 no overflow", {31'd0, status[0]}, 32'd0);
            check("R4 draining after stream", {31'd0, status[2]}, 32'd1);
            rd_req = 1'b1;
            idle(e + 2);
            rd_req = 1'b0;
            idle(3);
            check_seq("R3 order", mark, e + 2, base);
            check("R7 no underflow", {31'd0, status[1]}, 32'd0);
            check("R5 drain ended", {31'd0, status[2]}, 32'd0);

            // Phase C: overflow, then reset with data held
            base = 32'h3C00_0000 + (t << 8);
            do_reset();
            mark = out_cnt;
            for (int i = 0; i < DEPTH + 3; i++) begin
                wr_valid = 1'b1; wr_data = base + i;
                @(negedge clk);
            end
            wr_valid = 1'b0;
            check("R6 overflow sticky", {31'd0, status[0]}, 32'd1);
            check("R1 ready low when full", {31'd0, wr_ready}, 32'd0);
            // Clear and a dropped write in the same cycle: event wins
            clr_sticky = 1'b1; wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
            @(negedge clk);
            clr_sticky = 1'b0; wr_valid = 1'b0;
            check("R8 event beats clear", {31'd0, status[0]}, 32'd1);
            rd_req = 1'b1;
            idle(DEPTH);
            rd_req = 1'b0;
            idle(3);
            check_seq("R6 stored words kept", mark, DEPTH, base);

            for (int i = 0; i < 3; i++) begin
                wr_valid = 1'b1; wr_data = base + i;
                @(negedge clk);
            end
            wr_valid = 1'b0;
            do_reset();
            mark = out_cnt;
            rd_req = 1'b1;
            idle(5);
            rd_req = 1'b0;
            check("R9 buffer emptied", out_cnt - mark, 0);
            check("R9 status after reset", {29'd0, status}, 32'd0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule